// File: doc/BRIEF.md
# CAN Receive Pending Flag Bank

This block keeps one pending bit per mailbox for a 32-mailbox CAN controller. There are two independent sets: one records completed data-frame receptions and one records stored remote frames. The receive engine reports each stored frame as a single-cycle event that carries the mailbox number and the frame kind. A remote frame only marks its mailbox when that mailbox is configured to take remote frames. The configuration arrives as a 32-bit vector. Software reads each set as two 16-bit halves and acknowledges bits by writing ones.

Two summary flags, one per frame kind, collect the pending bits that are not hidden by the per-mailbox interrupt mask. Each summary flag drives its own interrupt line through a global mask bit. The event input has no back-pressure. Every pulse of `evt_valid` is taken in the cycle it appears, so the engine needs no ready signal. The register port is a plain strobe-and-address interface, and read data arrives one cycle after the address is presented.

Top module: `rx_pend_bank`

## Requirements
- R1: All pending bits reset to 0, the per-mailbox masks reset to all ones, both summary flags reset to 0 and both global mask bits reset to 1. Register address 0 holds data flags for mailboxes 0..15 (bit n = mailbox n). Address 1 holds data flags for mailboxes 16..31 (bit n = mailbox n+16). Addresses 2 and 3 hold the remote-frame flags with the same layout.
- R2: Writing a 1 to a bit at addresses 0..3 clears that pending bit. Writing a 0 leaves the bit as it was.
- R3: An event with `evt_frame`=0 (data) sets the data flag of mailbox `evt_mbx` at the next clock edge, whatever the remote configuration is.
- R4: An event with `evt_frame`=1 (remote) sets the remote flag of mailbox `evt_mbx` only when `rmt_cfg[evt_mbx]` is 1. Otherwise the event changes nothing.
- R5: A data event never sets a remote flag, and a remote event never sets a data flag.
- R6: When an event sets a bit and a write-one-to-clear hits the same bit in the same cycle, the bit ends up set.
- R7: Addresses 4 and 5 are read/write per-mailbox masks, with the same bit layout as the flag halves. A summary flag is set at the clock edge after any pending bit of its kind has a mask bit of 0. Masked pending bits do not contribute.
- R8: Address 6 holds the summary flags: bit 0 is the data summary and bit 1 is the remote summary. Writing 1 clears a flag. A cleared flag is set again one cycle later while any unmasked pending bit of its kind remains.
- R9: Address 7 holds the global masks: bit 0 for data and bit 1 for remote. `irq_data` is 1 exactly when the data summary is 1 and global bit 0 is 0. `irq_rmt` is 1 exactly when the remote summary is 1 and global bit 1 is 0.
- R10: `bus_rdata` shows the register selected by `bus_addr` as it was before the clock edge that captured it, one cycle after the address. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Single-cycle frame-stored event, always accepted |
| evt_mbx | input | 5 | Mailbox number of the event |
| evt_frame | input | 1 | Frame kind: 0 data, 1 remote |
| rmt_cfg | input | 32 | 1 marks a mailbox configured for remote reception |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after address |
| irq_data | output | 1 | Data-frame interrupt |
| irq_rmt | output | 1 | Remote-frame interrupt |

## Verification
The bench builds the block with its default parameters: 32 mailboxes and 16-bit registers. With these values every register has two halves, and the index wraps between mailboxes 15 and 16. The tests drive events to mailboxes 0, 15, 16 and 31, so both ends of each half and the high-half bit mapping are exercised. The same build reaches a remote event on an unconfigured mailbox, a set that lands in the same cycle as a clear, and a summary flag that is cleared while an unmasked bit is still pending.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  typedef enum logic {FRM_DATA = 1'b0, FRM_REMOTE = 1'b1} rxp_frame_e;
  localparam int unsigned SUM_DAT_BIT = 0;
  localparam int unsigned SUM_RMT_BIT = 1;
endpackage

// File: rtl/rxp_flag_bank.sv
// Set-dominant write-one-to-clear flag vector.
module rxp_flag_bank #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/rxp_mask_reg.sv
// Mask vector written in register-width slices.
module rxp_mask_reg #(
  parameter int unsigned N       = 32,
  parameter int unsigned W       = 16,
  localparam int unsigned HALVES = N / W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALVES-1:0] we,
  input  logic [W-1:0]      wdata,
  output logic [N-1:0]      q
);
  for (genvar h = 0; h < HALVES; h++) begin : g_slice
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[h*W +: W] <= '1;
      else if (we[h]) q[h*W +: W] <= wdata;
    end
  end
endmodule

// File: rtl/rxp_summary.sv
// Summary flag: set while any unmasked bit pends, cleared by write-one.
module rxp_summary #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend,
  input  logic [N-1:0] mask,
  input  logic         clr,
  output logic         flag
);
  logic hit;
  assign hit = |(pend & ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= (flag & ~clr) | hit;
  end
endmodule

// File: rtl/rx_pend_bank.sv
module rx_pend_bank
  import rxp_pkg::*;
#(
  parameter int unsigned NUM_MBX  = 32,
  parameter int unsigned REG_W    = 16,
  localparam int unsigned IDX_W    = $clog2(NUM_MBX),
  localparam int unsigned NUM_HALF = NUM_MBX / REG_W,
  localparam int unsigned ADDR_W   = $clog2(3 * NUM_HALF + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_valid,
  input  logic [IDX_W-1:0]   evt_mbx,
  input  logic               evt_frame,
  input  logic [NUM_MBX-1:0] rmt_cfg,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               irq_data,
  output logic               irq_rmt
);
  localparam int unsigned DAT_BASE = 0;
  localparam int unsigned RMT_BASE = NUM_HALF;
  localparam int unsigned MSK_BASE = 2 * NUM_HALF;
  localparam int unsigned SUM_ADDR = 3 * NUM_HALF;
  localparam int unsigned GMS_ADDR = 3 * NUM_HALF + 1;

  logic [NUM_MBX-1:0]  set_dat, set_rmt, clr_dat, clr_rmt;
  logic [NUM_MBX-1:0]  dat_flags, rmt_flags, mbx_mask;
  logic [NUM_HALF-1:0] mask_we;
  logic                sum_dat, sum_rmt;
  logic                clr_sum_dat, clr_sum_rmt;
  logic [1:0]          gmask;
  logic [REG_W-1:0]    rd_next;
  logic                is_rmt;

  assign is_rmt = (evt_frame == FRM_REMOTE);

  // Event decode and write-one-to-clear decode, one slice per mailbox.
  for (genvar i = 0; i < NUM_MBX; i++) begin : g_mbx
    localparam int unsigned H = i / REG_W;
    localparam int unsigned B = i % REG_W;
    logic hit_i;
    assign hit_i      = evt_valid && (evt_mbx == IDX_W'(i));
    assign set_dat[i] = hit_i && !is_rmt;
    assign set_rmt[i] = hit_i && is_rmt && rmt_cfg[i];
    assign clr_dat[i] = bus_wr && (bus_addr == ADDR_W'(DAT_BASE + H)) && bus_wdata[B];
    assign clr_rmt[i] = bus_wr && (bus_addr == ADDR_W'(RMT_BASE + H)) && bus_wdata[B];
  end

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_mwe
    assign mask_we[h] = bus_wr && (bus_addr == ADDR_W'(MSK_BASE + h));
  end

  assign clr_sum_dat = bus_wr && (bus_addr == ADDR_W'(SUM_ADDR)) && bus_wdata[SUM_DAT_BIT];
  assign clr_sum_rmt = bus_wr && (bus_addr == ADDR_W'(SUM_ADDR)) && bus_wdata[SUM_RMT_BIT];

  rxp_flag_bank #(.N(NUM_MBX)) u_dat_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_dat), .clr_vec(clr_dat), .flags(dat_flags));

  rxp_flag_bank #(.N(NUM_MBX)) u_rmt_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_rmt), .clr_vec(clr_rmt), .flags(rmt_flags));

  rxp_mask_reg #(.N(NUM_MBX), .W(REG_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .wdata(bus_wdata), .q(mbx_mask));

  rxp_summary #(.N(NUM_MBX)) u_sum_dat (
    .clk(clk), .rst_n(rst_n), .pend(dat_flags), .mask(mbx_mask),
    .clr(clr_sum_dat), .flag(sum_dat));

  rxp_summary #(.N(NUM_MBX)) u_sum_rmt (
    .clk(clk), .rst_n(rst_n), .pend(rmt_flags), .mask(mbx_mask),
    .clr(clr_sum_rmt), .flag(sum_rmt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gmask <= 2'b11;
    else if (bus_wr && (bus_addr == ADDR_W'(GMS_ADDR)))
      gmask <= {bus_wdata[SUM_RMT_BIT], bus_wdata[SUM_DAT_BIT]};
  end

  assign irq_data = sum_dat && !gmask[0];
  assign irq_rmt  = sum_rmt && !gmask[1];

  always_comb begin
    rd_next = '0;
    for (int unsigned h = 0; h < NUM_HALF; h++) begin
      if (bus_addr == ADDR_W'(DAT_BASE + h)) rd_next = dat_flags[h*REG_W +: REG_W];
      if (bus_addr == ADDR_W'(RMT_BASE + h)) rd_next = rmt_flags[h*REG_W +: REG_W];
      if (bus_addr == ADDR_W'(MSK_BASE + h)) rd_next = mbx_mask[h*REG_W +: REG_W];
    end
    if (bus_addr == ADDR_W'(SUM_ADDR)) begin
      rd_next[SUM_DAT_BIT] = sum_dat;
      rd_next[SUM_RMT_BIT] = sum_rmt;
    end
    if (bus_addr == ADDR_W'(GMS_ADDR)) begin
      rd_next[SUM_DAT_BIT] = gmask[0];
      rd_next[SUM_RMT_BIT] = gmask[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end
endmodule

// File: rtl/rxp_chk.sv
module rxp_chk
  import rxp_pkg::*;
#(
  parameter int unsigned NUM_MBX  = 32,
  parameter int unsigned REG_W    = 16,
  localparam int unsigned IDX_W    = $clog2(NUM_MBX),
  localparam int unsigned NUM_HALF = NUM_MBX / REG_W,
  localparam int unsigned ADDR_W   = $clog2(3 * NUM_HALF + 2)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               evt_valid,
  input logic [IDX_W-1:0]   evt_mbx,
  input logic               evt_frame,
  input logic [NUM_MBX-1:0] rmt_cfg,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               wbit0,
  input logic [REG_W-1:0]   bus_rdata,
  input logic [NUM_MBX-1:0] dat_flags,
  input logic [NUM_MBX-1:0] rmt_flags,
  input logic [NUM_MBX-1:0] mbx_mask,
  input logic               sum_dat,
  input logic               sum_rmt
);
  AST_DATA_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_frame == FRM_DATA |=> dat_flags[$past(evt_mbx)]); // R3

  AST_RMT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_frame == FRM_REMOTE && !rmt_cfg[evt_mbx] && !rmt_flags[evt_mbx]
    |=> !rmt_flags[$past(evt_mbx)]); // R4

  AST_NO_CROSS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && evt_frame == FRM_DATA |=> (rmt_flags & ~$past(rmt_flags)) == '0); // R5

  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == '0 && wbit0 && !(evt_valid && evt_mbx == '0 && evt_frame == FRM_DATA)
    |=> !dat_flags[0]); // R2

  AST_SUM_DAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    |(dat_flags & ~mbx_mask) |=> sum_dat); // R7

  AST_SUM_RMT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    |(rmt_flags & ~mbx_mask) |=> sum_rmt); // R8

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == '0 |=> bus_rdata == $past(dat_flags[REG_W-1:0])); // R10
endmodule

bind rx_pend_bank rxp_chk #(.NUM_MBX(NUM_MBX), .REG_W(REG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_mbx(evt_mbx),
  .evt_frame(evt_frame), .rmt_cfg(rmt_cfg), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wbit0(bus_wdata[0]), .bus_rdata(bus_rdata), .dat_flags(dat_flags),
  .rmt_flags(rmt_flags), .mbx_mask(mbx_mask), .sum_dat(sum_dat), .sum_rmt(sum_rmt));

// File: tb/rx_pend_bank_tb_top.sv
module rx_pend_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [4:0]  evt_mbx = '0;
  logic        evt_frame = 1'b0;
  logic [31:0] rmt_cfg = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_data, irq_rmt;

  rx_pend_bank dut_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_mbx(evt_mbx),
    .evt_frame(evt_frame), .rmt_cfg(rmt_cfg), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_data(irq_data), .irq_rmt(irq_rmt));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Requirement-level model
  logic [31:0] m_dat = '0, m_rmt = '0, m_mask = '1;
  logic        m_sd = 1'b0, m_sr = 1'b0;
  logic [1:0]  m_g = 2'b11;

  int n_chk = 0, n_bad = 0;
  logic rd_req = 1'b0, chk_due = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] reg_val(logic [2:0] a);
    case (a)
      3'd0: return m_dat[15:0];
      3'd1: return m_dat[31:16];
      3'd2: return m_rmt[15:0];
      3'd3: return m_rmt[31:16];
      3'd4: return m_mask[15:0];
      3'd5: return m_mask[31:16];
      3'd6: return {14'd0, m_sr, m_sd};
      default: return {14'd0, m_g};
    endcase
  endfunction

  always @(posedge clk) chk_due <= rd_req;

  // Monitor: pops one expected item per completed read
  always @(negedge clk) begin
    if (chk_due && exp_q.size() > 0) check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
  end

  task automatic tick();
    logic [31:0] set_d, set_r, clr_d, clr_r, nm;
    set_d = '0; set_r = '0; clr_d = '0; clr_r = '0; nm = m_mask;
    if (evt_valid && !evt_frame) set_d[evt_mbx] = 1'b1;
    if (evt_valid && evt_frame && rmt_cfg[evt_mbx]) set_r[evt_mbx] = 1'b1;
    if (bus_wr) begin
      case (bus_addr)
        3'd0: clr_d[15:0]  = bus_wdata;
        3'd1: clr_d[31:16] = bus_wdata;
        3'd2: clr_r[15:0]  = bus_wdata;
        3'd3: clr_r[31:16] = bus_wdata;
        3'd4: nm[15:0]     = bus_wdata;
        3'd5: nm[31:16]    = bus_wdata;
        default: ;
      endcase
    end
    @(posedge clk);
    m_sd   = (m_sd & !(bus_wr && bus_addr == 3'd6 && bus_wdata[0])) | (|(m_dat & ~m_mask));
    m_sr   = (m_sr & !(bus_wr && bus_addr == 3'd6 && bus_wdata[1])) | (|(m_rmt & ~m_mask));
    if (bus_wr && bus_addr == 3'd7) m_g = bus_wdata[1:0];
    m_dat  = (m_dat & ~clr_d) | set_d;
    m_rmt  = (m_rmt & ~clr_r) | set_r;
    m_mask = nm;
    @(negedge clk);
  endtask

  task automatic idle_in();
    evt_valid = 1'b0; bus_wr = 1'b0; rd_req = 1'b0;
  endtask

  task automatic op_idle(int n);
    idle_in();
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic op_evt(logic [4:0] mbx, logic remote);
    idle_in();
    evt_valid = 1'b1; evt_mbx = mbx; evt_frame = remote;
    tick();
  endtask

  task automatic op_wr(logic [2:0] a, logic [15:0] d);
    idle_in();
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
  endtask

  // Driver: pushes the expected read value, monitor compares it
  task automatic op_rd(logic [2:0] a, string tag);
    idle_in();
    bus_addr = a; rd_req = 1'b1;
    exp_q.push_back(reg_val(a));
    tag_q.push_back($sformatf("%s addr%0d", tag, a));
    tick();
  endtask

  task automatic chk_irq(string tag);
    check({tag, " irq"}, {14'd0, irq_rmt, irq_data}, {14'd0, m_sr & !m_g[1], m_sd & !m_g[0]});
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) op_rd(3'(a), "R1 reset");
    chk_irq("R9 reset");
    // R3 / R1 data set and half mapping, edge mailboxes
    op_evt(5'd3, 1'b0);  op_rd(3'd0, "R3 mbx3");
    op_evt(5'd20, 1'b0); op_rd(3'd1, "R1 mbx20");
    op_evt(5'd0, 1'b0);  op_evt(5'd15, 1'b0);
    op_evt(5'd16, 1'b0); op_evt(5'd31, 1'b0);
    op_rd(3'd0, "R1 low edges"); op_rd(3'd1, "R1 high edges");
    op_rd(3'd2, "R5 no remote"); op_rd(3'd3, "R5 no remote");
    // R4 remote gating
    op_evt(5'd5, 1'b1);  op_rd(3'd2, "R4 unconfigured");
    rmt_cfg = 32'h8000_0020;
    op_evt(5'd5, 1'b1);  op_rd(3'd2, "R4 configured");
    op_evt(5'd31, 1'b1); op_rd(3'd3, "R4 mbx31");
    op_rd(3'd0, "R5 data untouched");
    // R2 write-one-to-clear
    op_wr(3'd0, 16'h0000); op_rd(3'd0, "R2 zero write");
    op_wr(3'd0, 16'h0008); op_rd(3'd0, "R2 clear bit3");
    op_wr(3'd3, 16'h8000); op_rd(3'd3, "R2 clear remote31");
    // R6 set beats clear
    op_wr(3'd0, 16'h0001); op_rd(3'd0, "R6 pre");
    idle_in();
    evt_valid = 1'b1; evt_mbx = 5'd0; evt_frame = 1'b0;
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h0001;
    tick();
    op_rd(3'd0, "R6 set wins");
    // R7 masked pending does not summarize
    op_idle(2); op_rd(3'd6, "R7 all masked"); chk_irq("R7 masked");
    op_wr(3'd7, 16'h0000); op_rd(3'd7, "R10 gmask");
    op_wr(3'd4, 16'hFFFE); op_rd(3'd4, "R10 mask low");
    op_idle(1); op_rd(3'd6, "R7 unmasked"); chk_irq("R9 data irq");
    op_wr(3'd7, 16'h0001); chk_irq("R9 data gated");
    op_wr(3'd7, 16'h0000); chk_irq("R9 data regated");
    // R8 clear while still pending, then clear for good
    op_wr(3'd6, 16'h0001); op_rd(3'd6, "R8 cleared"); op_rd(3'd6, "R8 re-set");
    op_wr(3'd0, 16'h0001); op_wr(3'd6, 16'h0001);
    op_idle(1); op_rd(3'd6, "R8 stays clear"); chk_irq("R8 no irq");
    // remote summary through mailbox 5
    op_evt(5'd5, 1'b1);
    op_wr(3'd4, 16'hFFDF); op_idle(1);
    op_rd(3'd6, "R7 remote summary"); chk_irq("R9 remote irq");
    op_wr(3'd7, 16'h0002); chk_irq("R9 remote gated");
    op_idle(2);
    finish_run();
  end
endmodule